// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Sequencer for a 16-bit Register Machine

This block is the control core of a small 16-bit load/store processor. It keeps sixteen 16-bit general registers, a program counter and a condition flag. Every memory access goes through one byte-wide port that returns read data one cycle after the request. Each instruction word is fetched as two bytes, with the high byte at the lower address. Instructions of the extended class bring in one more 16-bit operand word the same way.

A decoder splits the instruction word into an operation, register indices and an 8-bit field. An arithmetic unit evaluates register-to-register operations and the three flag-setting compares. The sequencer steps through a short state chain for each instruction:

- register writeback;
- stack push and pop, using the top register as a stack pointer;
- word and byte loads and stores;
- relative branches and absolute jumps;
- subroutine call and return.

A character-output instruction shows up as a one-cycle strobe on an 8-bit data port. When the core fetches an all-zero instruction word it stops and raises `halted` until the next reset.

Top module: `seq16_core`

## Requirements
- R1: Instruction bits 15:14 give the class: 00 none, 01 one operand, 10 two registers, 11 extended with a trailing operand word. The high byte selects the operation: 01 ret, 02/03 debug no-ops, 41 neg, 42 not, 43 push, 44 pop, 47 out, 48 inc, 49 dec, 61 br, 62 jr, 81 add, 82 sub, 83 mul, 85 and, 86 or, 87 xor, 8A test, 8B cmp, 8C equ, 8D mov, 8E load, 8F stor, 90 loadb, 91 storb, C1 jmp, C2 call, E1 loadi. In the low byte, bits 7:4 hold the source register S (and the single register of one-operand forms and of loadi), bits 3:0 hold the destination D, and the whole byte is the relative offset.
- R2: Words are fetched big-endian, the byte at PC first and then the byte at PC+1. PC then advances by 2, and by another 2 after an extended operand word is fetched.
- R3: add, sub, mul, and, or, xor and mov put D op S (for mov, S) into D, truncated to 16 bits.
- R4: neg (two's complement), not (bitwise inversion), inc and dec rewrite the register named in bits 7:4.
- R5: test sets the flag when S AND D is nonzero, cmp when S < D unsigned, and equ when S == D. Otherwise each clears it. br jumps only while the flag is 1.
- R6: jr, and a taken br, set PC to PC + sign-extended offset − 2, where PC is the address past the branch word.
- R7: push subtracts 2 from r15 and then writes the source word at the new r15. pop reads the word at r15 into the register and then adds 2 to r15.
- R8: call subtracts 2 from r15, stores the address past its operand word at r15, and jumps to the operand. ret loads PC from the word at r15 and adds 2 to r15.
- R9: load and stor move a big-endian word between register D and memory: load reads at the address in S, stor writes S at the address in D. loadb zero-extends one byte. storb writes only the low byte of S, and the next byte is unchanged.
- R10: jmp loads PC from its operand word, and loadi copies its operand word into the register in bits 7:4.
- R11: out raises `out_valid` for exactly one cycle with the low byte of the register in bits 7:4 on `out_data`.
- R12: Fetching the word 0000 raises `halted`. It stays high with no further memory request until reset.
- R13: Reset clears all registers, the flag and PC. During reset nothing is written and nothing is output, and the first fetch reads address 0.
- R14: The debug codes 02/03 and unassigned codes change no register, flag or PC beyond the normal PC advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Byte address of the current access |
| mem_re | output | 1 | Read request; data is returned on `mem_rdata` in the next cycle |
| mem_we | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| out_valid | output | 1 | Character output strobe |
| out_data | output | 8 | Character byte |
| halted | output | 1 | Core has stopped on a zero instruction word |

## Verification
The bench builds the core with its default parameters: sixteen registers, r15 as the stack pointer and a reset PC of 0. It pairs the core with a 1 KiB byte memory in which the stack, code and data regions all fit. At this size, every register-arithmetic and compare operation is swept against a grid of operand pairs, including sign boundaries, zero and all-ones. Short hand-assembled programs reach backward relative branches, nested stack traffic, call/return addresses and partial-byte stores, and every result is observed through memory contents and the output strobe.

// File: rtl/seq16_pkg.sv
package seq16_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [4:0] {
    OP_NOP, OP_HALT, OP_RET,
    OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR, OP_MOV,
    OP_NEG, OP_NOT, OP_INC, OP_DEC,
    OP_TEST, OP_CMP, OP_EQU,
    OP_PUSH, OP_POP, OP_OUT, OP_BR, OP_JR,
    OP_LOAD, OP_STOR, OP_LOADB, OP_STORB,
    OP_JMP, OP_CALL, OP_LOADI
  } op_e;

  typedef struct packed {
    op_e        op;
    logic       ext;
    logic [3:0] src;
    logic [3:0] dst;
    logic [7:0] imm;
  } dec_t;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_DEC,
    S_X0, S_X1, S_X2, S_EXE,
    S_R0, S_R1, S_R2, S_B0, S_B1,
    S_W0, S_W1, S_HALT
  } st_e;

endpackage

// File: rtl/seq16_decode.sv
module seq16_decode
  import seq16_pkg::*;
(
  input  logic [WORD_W-1:0] ir,
  output dec_t              dec
);

  logic two_reg;
  assign two_reg = (ir[15:14] == 2'b10);

  always_comb begin
    dec.ext = (ir[15:14] == 2'b11);
    dec.imm = ir[7:0];
    dec.src = ir[7:4];
    dec.dst = two_reg ? ir[3:0] : ir[7:4];
    dec.op  = OP_NOP;
    if (ir == '0) begin
      dec.op = OP_HALT;
    end else begin
      unique case (ir[15:8])
        8'h01: dec.op = OP_RET;
        8'h41: dec.op = OP_NEG;
        8'h42: dec.op = OP_NOT;
        8'h43: dec.op = OP_PUSH;
        8'h44: dec.op = OP_POP;
        8'h47: dec.op = OP_OUT;
        8'h48: dec.op = OP_INC;
        8'h49: dec.op = OP_DEC;
        8'h61: dec.op = OP_BR;
        8'h62: dec.op = OP_JR;
        8'h81: dec.op = OP_ADD;
        8'h82: dec.op = OP_SUB;
        8'h83: dec.op = OP_MUL;
        8'h85: dec.op = OP_AND;
        8'h86: dec.op = OP_OR;
        8'h87: dec.op = OP_XOR;
        8'h8A: dec.op = OP_TEST;
        8'h8B: dec.op = OP_CMP;
        8'h8C: dec.op = OP_EQU;
        8'h8D: dec.op = OP_MOV;
        8'h8E: dec.op = OP_LOAD;
        8'h8F: dec.op = OP_STOR;
        8'h90: dec.op = OP_LOADB;
        8'h91: dec.op = OP_STORB;
        8'hC1: dec.op = OP_JMP;
        8'hC2: dec.op = OP_CALL;
        8'hE1: dec.op = OP_LOADI;
        default: dec.op = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/seq16_alu.sv
module seq16_alu
  import seq16_pkg::*;
(
  input  op_e               op,
  input  logic [WORD_W-1:0] a_src,
  input  logic [WORD_W-1:0] b_dst,
  output logic [WORD_W-1:0] res,
  output logic              res_we,
  output logic              flag_we,
  output logic              flag_val
);

  always_comb begin
    res      = '0;
    res_we   = 1'b1;
    flag_we  = 1'b0;
    flag_val = 1'b0;
    unique case (op)
      OP_ADD:  res = b_dst + a_src;
      OP_SUB:  res = b_dst - a_src;
      OP_MUL:  res = b_dst * a_src;
      OP_AND:  res = b_dst & a_src;
      OP_OR:   res = b_dst | a_src;
      OP_XOR:  res = b_dst ^ a_src;
      OP_MOV:  res = a_src;
      OP_NEG:  res = '0 - a_src;
      OP_NOT:  res = ~a_src;
      OP_INC:  res = a_src + 1'b1;
      OP_DEC:  res = a_src - 1'b1;
      OP_TEST: begin
        res_we = 1'b0; flag_we = 1'b1; flag_val = |(a_src & b_dst);
      end
      OP_CMP: begin
        res_we = 1'b0; flag_we = 1'b1; flag_val = (a_src < b_dst);
      end
      OP_EQU: begin
        res_we = 1'b0; flag_we = 1'b1; flag_val = (a_src == b_dst);
      end
      default: res_we = 1'b0;
    endcase
  end

endmodule

// File: rtl/seq16_regfile.sv
module seq16_regfile
  import seq16_pkg::*;
#(
  parameter int unsigned REG_CNT = 16,
  parameter int unsigned SP_IDX  = 15,
  localparam int unsigned IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic [WORD_W-1:0] wa_data,
  input  logic              sp_en,
  input  logic [WORD_W-1:0] sp_wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [WORD_W-1:0] ra_data,
  output logic [WORD_W-1:0] rb_data,
  output logic [WORD_W-1:0] sp_data
);

  logic [WORD_W-1:0] rf [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic [WORD_W-1:0] q;
    logic              hit_a;
    logic              hit_sp;
    assign hit_a  = wa_en && (wa_idx == IDX_W'(g));
    assign hit_sp = sp_en && (g == SP_IDX);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (hit_a)  q <= wa_data;
      else if (hit_sp) q <= sp_wdata;
    end
    assign rf[g] = q;
  end

  assign ra_data = rf[ra_idx];
  assign rb_data = rf[rb_idx];
  assign sp_data = rf[SP_IDX];

endmodule

// File: rtl/seq16_core.sv
module seq16_core
  import seq16_pkg::*;
#(
  parameter int unsigned REG_CNT  = 16,
  parameter int unsigned SP_IDX   = 15,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  output logic        mem_re,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        halted
);

  localparam int unsigned IDX_W = $clog2(REG_CNT);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

  st_e               state, state_n;
  logic [WORD_W-1:0] pc, pc_n, ir, opnd, dad, dad_n, wword, wword_n;
  logic [BYTE_W-1:0] hold_b;
  logic              flag, flag_n, to_pc, to_pc_n;
  logic              pc_en, ir_hi_en, ir_lo_en, hold_en, opnd_en, dad_en, wword_en, flag_en, to_pc_en;

  dec_t              dec;
  logic [WORD_W-1:0] ra_data, rb_data, sp_data, alu_res;
  logic              alu_we, alu_fwe, alu_fval;
  logic              wa_en, sp_en;
  logic [IDX_W-1:0]  wa_idx;
  logic [WORD_W-1:0] wa_data, sp_wdata, rel_tgt;

  seq16_decode u_dec (.ir(ir), .dec(dec));

  seq16_alu u_alu (
    .op(dec.op), .a_src(ra_data), .b_dst(rb_data),
    .res(alu_res), .res_we(alu_we), .flag_we(alu_fwe), .flag_val(alu_fval)
  );

  seq16_regfile #(.REG_CNT(REG_CNT), .SP_IDX(SP_IDX)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
    .sp_en(sp_en), .sp_wdata(sp_wdata),
    .ra_idx(IDX_W'(dec.src)), .rb_idx(IDX_W'(dec.dst)),
    .ra_data(ra_data), .rb_data(rb_data), .sp_data(sp_data)
  );

  assign rel_tgt = pc + {{(WORD_W-BYTE_W){dec.imm[BYTE_W-1]}}, dec.imm} - STEP;
  assign halted  = (state == S_HALT);

  always_comb begin
    state_n   = state;
    pc_en = 1'b0;   pc_n = pc;
    ir_hi_en = 1'b0; ir_lo_en = 1'b0; hold_en = 1'b0; opnd_en = 1'b0;
    dad_en = 1'b0;  dad_n = dad;
    wword_en = 1'b0; wword_n = wword;
    flag_en = 1'b0; flag_n = flag;
    to_pc_en = 1'b0; to_pc_n = to_pc;
    wa_en = 1'b0;   wa_idx = IDX_W'(dec.dst); wa_data = alu_res;
    sp_en = 1'b0;   sp_wdata = sp_data;
    mem_addr = pc;  mem_re = 1'b0; mem_we = 1'b0; mem_wdata = '0;
    out_valid = 1'b0; out_data = ra_data[BYTE_W-1:0];
    unique case (state)
      S_F0: begin mem_re = 1'b1; state_n = S_F1; end
      S_F1: begin mem_re = 1'b1; mem_addr = pc + 1'b1; ir_hi_en = 1'b1; state_n = S_F2; end
      S_F2: begin ir_lo_en = 1'b1; pc_en = 1'b1; pc_n = pc + STEP; state_n = S_DEC; end
      S_DEC: begin
        if (dec.op == OP_HALT) state_n = S_HALT;
        else if (dec.ext)      state_n = S_X0;
        else                   state_n = S_EXE;
      end
      S_X0: begin mem_re = 1'b1; state_n = S_X1; end
      S_X1: begin mem_re = 1'b1; mem_addr = pc + 1'b1; hold_en = 1'b1; state_n = S_X2; end
      S_X2: begin opnd_en = 1'b1; pc_en = 1'b1; pc_n = pc + STEP; state_n = S_EXE; end
      S_EXE: begin
        state_n = S_F0;
        if (alu_we) wa_en = 1'b1;
        if (alu_fwe) begin flag_en = 1'b1; flag_n = alu_fval; end
        unique case (dec.op)
          OP_PUSH: begin
            sp_en = 1'b1; sp_wdata = sp_data - STEP;
            dad_en = 1'b1; dad_n = sp_data - STEP;
            wword_en = 1'b1; wword_n = ra_data; state_n = S_W0;
          end
          OP_CALL: begin
            sp_en = 1'b1; sp_wdata = sp_data - STEP;
            dad_en = 1'b1; dad_n = sp_data - STEP;
            wword_en = 1'b1; wword_n = pc;
            pc_en = 1'b1; pc_n = opnd; state_n = S_W0;
          end
          OP_POP, OP_RET: begin
            sp_en = 1'b1; sp_wdata = sp_data + STEP;
            dad_en = 1'b1; dad_n = sp_data;
            to_pc_en = 1'b1; to_pc_n = (dec.op == OP_RET); state_n = S_R0;
          end
          OP_LOAD: begin
            dad_en = 1'b1; dad_n = ra_data;
            to_pc_en = 1'b1; to_pc_n = 1'b0; state_n = S_R0;
          end
          OP_LOADB: begin dad_en = 1'b1; dad_n = ra_data; state_n = S_B0; end
          OP_STOR: begin
            dad_en = 1'b1; dad_n = rb_data;
            wword_en = 1'b1; wword_n = ra_data; state_n = S_W0;
          end
          OP_STORB: begin
            mem_we = 1'b1; mem_addr = rb_data; mem_wdata = ra_data[BYTE_W-1:0];
          end
          OP_BR:    if (flag) begin pc_en = 1'b1; pc_n = rel_tgt; end
          OP_JR:    begin pc_en = 1'b1; pc_n = rel_tgt; end
          OP_JMP:   begin pc_en = 1'b1; pc_n = opnd; end
          OP_LOADI: begin wa_en = 1'b1; wa_data = opnd; end
          OP_OUT:   out_valid = 1'b1;
          default: ;
        endcase
      end
      S_R0: begin mem_re = 1'b1; mem_addr = dad; state_n = S_R1; end
      S_R1: begin mem_re = 1'b1; mem_addr = dad + 1'b1; hold_en = 1'b1; state_n = S_R2; end
      S_R2: begin
        if (to_pc) begin pc_en = 1'b1; pc_n = {hold_b, mem_rdata}; end
        else begin wa_en = 1'b1; wa_data = {hold_b, mem_rdata}; end
        state_n = S_F0;
      end
      S_B0: begin mem_re = 1'b1; mem_addr = dad; state_n = S_B1; end
      S_B1: begin
        wa_en = 1'b1; wa_data = {{(WORD_W-BYTE_W){1'b0}}, mem_rdata}; state_n = S_F0;
      end
      S_W0: begin mem_we = 1'b1; mem_addr = dad; mem_wdata = wword[15:8]; state_n = S_W1; end
      S_W1: begin
        mem_we = 1'b1; mem_addr = dad + 1'b1; mem_wdata = wword[7:0]; state_n = S_F0;
      end
      S_HALT: state_n = S_HALT;
      default: state_n = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_F0;
      pc    <= RESET_PC;
      ir    <= '0;
      hold_b <= '0;
      opnd  <= '0;
      dad   <= '0;
      wword <= '0;
      flag  <= 1'b0;
      to_pc <= 1'b0;
    end else begin
      state <= state_n;
      if (pc_en)    pc          <= pc_n;
      if (ir_hi_en) ir[15:8]    <= mem_rdata;
      if (ir_lo_en) ir[7:0]     <= mem_rdata;
      if (hold_en)  hold_b      <= mem_rdata;
      if (opnd_en)  opnd        <= {hold_b, mem_rdata};
      if (dad_en)   dad         <= dad_n;
      if (wword_en) wword       <= wword_n;
      if (flag_en)  flag        <= flag_n;
      if (to_pc_en) to_pc       <= to_pc_n;
    end
  end

endmodule

// File: rtl/seq16_core_chk.sv
module seq16_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] mem_addr,
  input logic        mem_re,
  input logic        mem_we,
  input logic        out_valid,
  input logic        halted
);

  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r12_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_re && !mem_we));

  a_r11_out_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r11_out_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!mem_we && !mem_re));

  a_r2_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  a_r9_word_write_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 16'd1));

endmodule

bind seq16_core seq16_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
  .mem_we(mem_we), .out_valid(out_valid), .halted(halted)
);

// File: tb/seq16_core_tb.sv
`timescale 1ns/1ps
module seq16_core_tb_top;

  localparam int MEM_BYTES = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we, out_valid, halted;
  logic [7:0]  mem_wdata, out_data;
  logic [7:0]  mem_rdata;

  logic [7:0]  mem [MEM_BYTES];
  logic        clr = 1'b0, ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;

  logic [7:0]  img [64];
  int          plen;
  logic [7:0]  outs [16];
  int          n_out;
  logic [15:0] rd_trace [8];
  int          n_rd;
  int          checks = 0, failures = 0;

  always #2 clk = ~clk;

  seq16_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .halted(halted)
  );

  always @(posedge clk) begin
    if (clr) for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
    else if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && n_out < 16) begin outs[n_out] = out_data; n_out++; end
    if (rst_n && mem_re && n_rd < 8) begin rd_trace[n_rd] = mem_addr; n_rd++; end
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rdw(input int a);
    return {mem[a], mem[a+1]};
  endfunction

  task automatic begin_prog();
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    plen = 2;
  endtask

  task automatic put_w(input int a, input logic [15:0] w);
    img[a] = w[15:8]; img[a+1] = w[7:0];
    if (a + 2 > plen) plen = a + 2;
  endtask

  task automatic load_prog();
    rst_n = 1'b0;
    n_out = 0; n_rd = 0;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    for (int i = 0; i < plen; i++) begin
      ld_en = 1'b1; ld_addr = 10'(i); ld_data = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    ld_en = 1'b1; ld_addr = 10'(a); ld_data = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic go(input string tag);
    int cyc;
    @(negedge clk); rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 3000) begin @(negedge clk); cyc++; end
    chk(halted, {tag, " halt reached"}, 32'(halted), 32'd1);
  endtask

  function automatic logic [15:0] exp_alu(input logic [7:0] opc, input logic [15:0] s, input logic [15:0] d);
    case (opc)
      8'h81: return d + s;
      8'h82: return d - s;
      8'h83: return d * s;
      8'h85: return d & s;
      8'h86: return d | s;
      8'h87: return d ^ s;
      8'h8D: return s;
      8'h41: return 16'd0 - d;
      8'h42: return ~d;
      8'h48: return d + 16'd1;
      8'h49: return d - 16'd1;
      8'h8A: return {15'd0, (s & d) == 16'd0};
      8'h8B: return {15'd0, !(s < d)};
      8'h8C: return {15'd0, s != d};
      default: return 16'hxxxx;
    endcase
  endfunction

  logic [15:0] va [6] = '{16'h0000, 16'h0001, 16'h8000, 16'h1234, 16'hFFFE, 16'h7FFF};
  logic [15:0] vb [6] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h00FF, 16'h0003, 16'h0001};
  logic [7:0]  ops2 [7] = '{8'h81, 8'h82, 8'h83, 8'h85, 8'h86, 8'h87, 8'h8D};
  logic [7:0]  ops1 [4] = '{8'h41, 8'h42, 8'h48, 8'h49};
  logic [7:0]  opsf [3] = '{8'h8A, 8'h8B, 8'h8C};

  initial begin
    // R13: reset state
    begin_prog();
    load_prog();
    chk(!mem_we && !out_valid && !halted, "R13 quiet during reset",
        {29'd0, mem_we, out_valid, halted}, 32'd0);
    go("R12 immediate zero word");
    chk(n_rd == 2 && rd_trace[0] == 16'h0000 && rd_trace[1] == 16'h0001, "R13 first fetch at 0",
        32'(rd_trace[0]), 32'd0);

    // R3/R14: two-register ops with debug no-ops around them
    foreach (ops2[k]) for (int p = 0; p < 6; p++) begin
      begin_prog();
      put_w(0, 16'hE110); put_w(2, va[p]);
      put_w(4, 16'hE120); put_w(6, vb[p]);
      put_w(8, 16'h0300);
      put_w(10, {ops2[k], 8'h12});
      put_w(12, 16'h0200);
      put_w(14, 16'hE130); put_w(16, 16'h0300);
      put_w(18, 16'h8F23);
      load_prog(); go("R3");
      chk(rdw(16'h300) == exp_alu(ops2[k], va[p], vb[p]), $sformatf("R3 op %h R14 debug", ops2[k]),
          32'(rdw(16'h300)), 32'(exp_alu(ops2[k], va[p], vb[p])));
    end

    // R4: single-register ops on r2
    foreach (ops1[k]) for (int p = 0; p < 6; p++) begin
      begin_prog();
      put_w(0, 16'hE120); put_w(2, vb[p]);
      put_w(4, {ops1[k], 8'h20});
      put_w(6, 16'hE130); put_w(8, 16'h0300);
      put_w(10, 16'h8F23);
      load_prog(); go("R4");
      chk(rdw(16'h300) == exp_alu(ops1[k], 16'h0, vb[p]), $sformatf("R4 op %h", ops1[k]),
          32'(rdw(16'h300)), 32'(exp_alu(ops1[k], 16'h0, vb[p])));
    end

    // R5/R6: compares followed by br over an inc (r4 stays 0 when flag set)
    foreach (opsf[k]) for (int p = 0; p < 6; p++) for (int sw = 0; sw < 2; sw++) begin
      logic [15:0] s, d;
      s = sw ? vb[p] : va[p]; d = sw ? va[p] : vb[p];
      begin_prog();
      put_w(0, 16'hE110); put_w(2, s);
      put_w(4, 16'hE120); put_w(6, d);
      put_w(8, 16'h8D00);
      put_w(10, {opsf[k], 8'h12});
      put_w(12, 16'h6104);
      put_w(14, 16'h4840);
      put_w(16, 16'hE130); put_w(18, 16'h0300);
      put_w(20, 16'h8F43);
      load_prog(); go("R5");
      chk(rdw(16'h300) == exp_alu(opsf[k], s, d), $sformatf("R5 flag op %h", opsf[k]),
          32'(rdw(16'h300)), 32'(exp_alu(opsf[k], s, d)));
    end

    // R6/R2/R11: countdown loop with backward jr
    begin_prog();
    put_w(0, 16'hE110); put_w(2, 16'h0003);
    put_w(4, 16'h4710); put_w(6, 16'h4910);
    put_w(8, 16'h8C10); put_w(10, 16'h6104);
    put_w(12, 16'h62F8);
    load_prog(); go("R6");
    chk(n_out == 3, "R6 loop count", 32'(n_out), 32'd3);
    chk(outs[0] == 8'd3 && outs[1] == 8'd2 && outs[2] == 8'd1, "R11 out sequence",
        {8'd0, outs[0], outs[1], outs[2]}, 32'h00030201);
    chk(rd_trace[2] == 16'h0002 && rd_trace[3] == 16'h0003 && rd_trace[4] == 16'h0004 && rd_trace[5] == 16'h0005,
        "R2 fetch order", {rd_trace[2], rd_trace[4]}, 32'h00020004);

    // R12: halted stays and port idle
    begin
      bit quiet; quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!halted || mem_re || mem_we) quiet = 1'b0;
      end
      chk(quiet, "R12 halted holds", 32'(quiet), 32'd1);
    end

    // R7: push then pop
    begin_prog();
    put_w(0, 16'hE1F0); put_w(2, 16'h0200);
    put_w(4, 16'hE110); put_w(6, 16'hABCD);
    put_w(8, 16'h4310); put_w(10, 16'h4420);
    put_w(12, 16'hE130); put_w(14, 16'h0300);
    put_w(16, 16'h8F23);
    put_w(18, 16'hE130); put_w(20, 16'h0302);
    put_w(22, 16'h8FF3);
    load_prog(); go("R7");
    chk(rdw(16'h1FE) == 16'hABCD, "R7 push image", 32'(rdw(16'h1FE)), 32'h0000ABCD);
    chk(rdw(16'h300) == 16'hABCD, "R7 pop value", 32'(rdw(16'h300)), 32'h0000ABCD);
    chk(rdw(16'h302) == 16'h0200, "R7 sp restored", 32'(rdw(16'h302)), 32'h00000200);

    // R8: call and return
    begin_prog();
    put_w(0, 16'hE1F0); put_w(2, 16'h0200);
    put_w(4, 16'hC200); put_w(6, 16'h0020);
    put_w(8, 16'h4730);
    put_w(10, 16'hE150); put_w(12, 16'h0310);
    put_w(14, 16'h8FF5);
    put_w(32, 16'hE130); put_w(34, 16'h0041);
    put_w(36, 16'h0100);
    load_prog(); go("R8");
    chk(rdw(16'h1FE) == 16'h0008, "R8 return address", 32'(rdw(16'h1FE)), 32'h8);
    chk(n_out == 1 && outs[0] == 8'h41, "R8 body then return", 32'(outs[0]), 32'h41);
    chk(rdw(16'h310) == 16'h0200, "R8 sp after ret", 32'(rdw(16'h310)), 32'h200);

    // R9: byte and word memory moves
    begin_prog();
    put_w(0, 16'hE110); put_w(2, 16'h0300);
    put_w(4, 16'hE120); put_w(6, 16'h12FE);
    put_w(8, 16'h9121); put_w(10, 16'h9013);
    put_w(12, 16'hE140); put_w(14, 16'h0310);
    put_w(16, 16'h8F34); put_w(18, 16'h8E15);
    put_w(20, 16'hE140); put_w(22, 16'h0312);
    put_w(24, 16'h8F54);
    load_prog(); poke(16'h301, 8'h77); go("R9");
    chk(mem[16'h300] == 8'hFE && mem[16'h301] == 8'h77, "R9 storb one byte",
        32'(rdw(16'h300)), 32'h0000FE77);
    chk(rdw(16'h310) == 16'h00FE, "R9 loadb zero-extend", 32'(rdw(16'h310)), 32'h00FE);
    chk(rdw(16'h312) == 16'hFE77, "R9 load word", 32'(rdw(16'h312)), 32'hFE77);

    // R10/R14: jmp over code, unassigned code is harmless
    begin_prog();
    put_w(0, 16'hC100); put_w(2, 16'h0010);
    put_w(4, 16'h4710);
    put_w(16, 16'hE110); put_w(18, 16'h005A);
    put_w(20, 16'hBF12);
    put_w(22, 16'h4710);
    load_prog(); go("R10");
    chk(n_out == 1 && outs[0] == 8'h5A, "R10 jmp and loadi R14 unassigned", 32'(outs[0]), 32'h5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule